// File: doc/BRIEF.md
# Global-History Two-Level Branch Direction Predictor

This block predicts whether a conditional branch is taken. It keeps a table of 2^TBL_BITS two-bit saturating counters and a shift register with the outcomes of the most recent conditional branches. The table is arranged as 2^COL_BITS columns by 2^(TBL_BITS-COL_BITS) rows. Low branch-address bits select the column. The row comes from the global history, either used directly or XORed with the remaining address bits. The parameter COL_BITS may take any value from 0 to TBL_BITS. At one end the predictor is a plain address-indexed counter table, and at the other it is a single column indexed only by history.

A fetch stage presents a branch address on the lookup port and gets the predicted direction in the same cycle. When the branch resolves, the pipeline presents the address and the real outcome on the update port. On that clock edge the selected counter is trained and the outcome is shifted into the history. Both address ports carry the branch address with the instruction-alignment bits already removed.

Top module: `gbp_predictor`

## Requirements
- R1: After reset every counter holds 01 (weakly not taken) and the history is all zeros, so any lookup returns lk_ctr=01 and lk_pred=0.
- R2: lk_ctr shows the counter selected by the lookup index, and lk_pred equals bit 1 of that counter (1 means taken).
- R3: An update with upd_taken=1 moves the selected counter up by one and stops at 11. An update with upd_taken=0 moves it down by one and stops at 00.
- R4: An update shifts the history left by one place and drops the oldest bit. The new bit 0 is 1 for taken and 0 for not taken. While upd_valid=0 neither the history nor any counter changes, whatever upd_addr and upd_taken carry.
- R5: The column number is addr[COL_BITS-1:0], and the table index is {row, column}. With COL_BITS=0 there is one column.
- R6: With hash_mode=0 the row equals the history (TBL_BITS-COL_BITS bits). With COL_BITS=TBL_BITS there is one row, and the index is the address alone.
- R7: With hash_mode=1 the row equals the history XORed bitwise with addr[TBL_BITS-1:COL_BITS]. Update and lookup form their indices the same way, from the current history and mode.
- R8: A lookup is combinational. A lookup in the same cycle as an update sees the counter and history from before that update, and sees the new values after the clock edge.
- R9: All values of COL_BITS from 0 to TBL_BITS build and follow R5 to R7, including COL_BITS=0 and COL_BITS=TBL_BITS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hash_mode | input | 1 | 1: row is history XOR address, 0: row is history |
| lk_addr | input | TBL_BITS | Branch address for the lookup |
| lk_pred | output | 1 | Predicted direction, 1 = taken |
| lk_ctr | output | 2 | State of the selected counter |
| upd_valid | input | 1 | Resolved branch present this cycle |
| upd_addr | input | TBL_BITS | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch |

## Verification
Lookup outputs depend only on the inputs and on stored state, so they are due in the same cycle the address is applied. The bench drives every input on the falling edge and samples lk_ctr and lk_pred 1 ns later, still in the low half of the clock. An update takes effect at the next rising edge, so a counter or history change is first visible at the lookup made on the following falling edge. The same-cycle case is sampled once before that edge and once after it. Three instances run side by side, with COL_BITS at 2, at TBL_BITS and at 0, and a bench model built from the requirements gives the expected counter for every lookup.

// File: rtl/gbp_pkg.sv
package gbp_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_e;

    localparam logic [1:0] CTR_RESET = CTR_WEAK_NT;

    // Saturating step of one two-bit counter toward the real outcome.
    function automatic logic [1:0] ctr_train(input logic [1:0] cur, input logic taken);
        logic [1:0] nxt;
        nxt = cur;
        if (taken) begin
            if (cur != CTR_STRONG_T) nxt = cur + 2'd1;
        end else begin
            if (cur != CTR_STRONG_NT) nxt = cur - 2'd1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/gbp_history.sv
module gbp_history #(
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              taken,
    output logic [HIST_W-1:0] hist_q
);

    typedef struct packed {
        logic [HIST_W-1:0] bits;
    } hist_state_t;

    hist_state_t state_d;
    hist_state_t state_q;
    logic [HIST_W-1:0] shifted;

    generate
        if (HIST_W == 1) begin : g_one_bit
            assign shifted = taken;
        end else begin : g_multi_bit
            assign shifted = {state_q.bits[HIST_W-2:0], taken};
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        if (shift_en) begin
            state_d.bits = shifted;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign hist_q = state_q.bits;

endmodule

// File: rtl/gbp_index_gen.sv
module gbp_index_gen #(
    parameter int TBL_BITS = 6,
    parameter int COL_BITS = 2,
    parameter int HIST_W   = 4
) (
    input  logic [TBL_BITS-1:0] addr,
    input  logic [HIST_W-1:0]   hist,
    input  logic                hash_mode,
    output logic [TBL_BITS-1:0] idx
);

    localparam int ROW_BITS = TBL_BITS - COL_BITS;

    generate
        if (ROW_BITS == 0) begin : g_addr_only
            assign idx = addr;
        end else begin : g_with_rows
            logic [ROW_BITS-1:0] row;
            always_comb begin
                if (hash_mode) begin
                    row = hist[ROW_BITS-1:0] ^ addr[TBL_BITS-1:COL_BITS];
                end else begin
                    row = hist[ROW_BITS-1:0];
                end
            end
            if (COL_BITS == 0) begin : g_single_col
                assign idx = row;
            end else begin : g_row_col
                assign idx = {row, addr[COL_BITS-1:0]};
            end
        end
    endgenerate

endmodule

// File: rtl/gbp_ctr_table.sv
module gbp_ctr_table
    import gbp_pkg::*;
#(
    parameter int TBL_BITS = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [TBL_BITS-1:0]       rd_idx,
    output logic [1:0]                rd_ctr,
    input  logic                      wr_en,
    input  logic [TBL_BITS-1:0]       wr_idx,
    input  logic                      wr_taken,
    output logic [2*(2**TBL_BITS)-1:0] ctr_flat
);

    localparam int ENTRIES = 2 ** TBL_BITS;

    typedef struct packed {
        logic [ENTRIES-1:0][1:0] cells;
    } tbl_state_t;

    tbl_state_t state_d;
    tbl_state_t state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.cells[wr_idx] = ctr_train(state_q.cells[wr_idx], wr_taken);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.cells <= {ENTRIES{CTR_RESET}};
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_ctr   = state_q.cells[rd_idx];
    assign ctr_flat = state_q.cells;

endmodule

// File: rtl/gbp_predictor.sv
module gbp_predictor #(
    parameter int TBL_BITS = 6,
    parameter int COL_BITS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hash_mode,
    input  logic [TBL_BITS-1:0] lk_addr,
    output logic                lk_pred,
    output logic [1:0]          lk_ctr,
    input  logic                upd_valid,
    input  logic [TBL_BITS-1:0] upd_addr,
    input  logic                upd_taken
);

    localparam int ROW_BITS = TBL_BITS - COL_BITS;
    localparam int HIST_W   = (ROW_BITS > 0) ? ROW_BITS : 1;
    localparam int ENTRIES  = 2 ** TBL_BITS;

    logic [HIST_W-1:0]    hist_q;
    logic [TBL_BITS-1:0]  lk_idx;
    logic [TBL_BITS-1:0]  upd_idx;
    logic [1:0]           rd_ctr;
    logic [2*ENTRIES-1:0] ctr_flat;

    gbp_history #(
        .HIST_W (HIST_W)
    ) hist_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd_valid),
        .taken    (upd_taken),
        .hist_q   (hist_q)
    );

    gbp_index_gen #(
        .TBL_BITS (TBL_BITS),
        .COL_BITS (COL_BITS),
        .HIST_W   (HIST_W)
    ) lk_index_i (
        .addr      (lk_addr),
        .hist      (hist_q),
        .hash_mode (hash_mode),
        .idx       (lk_idx)
    );

    gbp_index_gen #(
        .TBL_BITS (TBL_BITS),
        .COL_BITS (COL_BITS),
        .HIST_W   (HIST_W)
    ) upd_index_i (
        .addr      (upd_addr),
        .hist      (hist_q),
        .hash_mode (hash_mode),
        .idx       (upd_idx)
    );

    gbp_ctr_table #(
        .TBL_BITS (TBL_BITS)
    ) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (lk_idx),
        .rd_ctr   (rd_ctr),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken),
        .ctr_flat (ctr_flat)
    );

    assign lk_ctr  = rd_ctr;
    assign lk_pred = rd_ctr[1];

endmodule

// File: rtl/gbp_checker.sv
module gbp_checker #(
    parameter int TBL_BITS = 6,
    parameter int HIST_W   = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        upd_valid,
    input logic                        upd_taken,
    input logic [TBL_BITS-1:0]         upd_idx,
    input logic [HIST_W-1:0]           hist_q,
    input logic [2*(2**TBL_BITS)-1:0]  ctr_flat
);

    localparam int ENTRIES = 2 ** TBL_BITS;

    logic                prev_valid;
    logic                prev_taken;
    logic [TBL_BITS-1:0] prev_idx;
    logic [1:0]          prev_old;
    logic [1:0]          step_exp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_valid <= 1'b0;
            prev_taken <= 1'b0;
            prev_idx   <= '0;
            prev_old   <= 2'b01;
        end else begin
            prev_valid <= upd_valid;
            prev_taken <= upd_taken;
            prev_idx   <= upd_idx;
            prev_old   <= ctr_flat[{upd_idx, 1'b0} +: 2];
        end
    end

    always_comb begin
        case ({prev_taken, prev_old})
            3'b100:  step_exp = 2'b01;
            3'b101:  step_exp = 2'b10;
            3'b110:  step_exp = 2'b11;
            3'b111:  step_exp = 2'b11;
            3'b000:  step_exp = 2'b00;
            3'b001:  step_exp = 2'b00;
            3'b010:  step_exp = 2'b01;
            default: step_exp = 2'b10;
        endcase
    end

    // R1: state right after reset release
    a_r1_reset_hist: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (hist_q == '0));

    a_r1_reset_ctrs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctr_flat == {ENTRIES{2'b01}}));

    // R3: trained counter moved one step toward the outcome, saturating
    a_r3_train_step: assert property (@(posedge clk) disable iff (!rst_n)
        prev_valid |-> (ctr_flat[{prev_idx, 1'b0} +: 2] == step_exp));

    // R4: no update leaves history and table untouched
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> ($stable(hist_q) && $stable(ctr_flat)));

    // R4: newest outcome enters bit 0
    a_r4_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (hist_q[0] == $past(upd_taken)));

    generate
        if (HIST_W > 1) begin : g_shift_up
            // R4: older outcomes move up one place
            a_r4_shift_up: assert property (@(posedge clk) disable iff (!rst_n)
                upd_valid |=> (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])));
        end
    endgenerate

endmodule

bind gbp_predictor gbp_checker #(
    .TBL_BITS (TBL_BITS),
    .HIST_W   (HIST_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_taken (upd_taken),
    .upd_idx   (upd_idx),
    .hist_q    (hist_q),
    .ctr_flat  (ctr_flat)
);

// File: tb/gbp_predictor_tb_top.sv
module gbp_predictor_tb_top;

    localparam int TB = 6;
    localparam int NINST = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hash_mode = 1'b0;
    logic [TB-1:0] lk_addr = '0;
    logic          upd_valid = 1'b0;
    logic [TB-1:0] upd_addr = '0;
    logic          upd_taken = 1'b0;

    logic [1:0] ctr_o [NINST];
    logic       pred_o [NINST];

    int checks = 0;
    int failures = 0;
    int mctr [NINST][64];
    int mhist [NINST];
    bit done = 0;

    always #4 clk = ~clk;

    // instance 0: mixed split, 1: address only, 2: history only (R9)
    gbp_predictor #(.TBL_BITS(TB), .COL_BITS(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .hash_mode(hash_mode), .lk_addr(lk_addr),
        .lk_pred(pred_o[0]), .lk_ctr(ctr_o[0]), .upd_valid(upd_valid),
        .upd_addr(upd_addr), .upd_taken(upd_taken));

    gbp_predictor #(.TBL_BITS(TB), .COL_BITS(TB)) dut_addr_i (
        .clk(clk), .rst_n(rst_n), .hash_mode(hash_mode), .lk_addr(lk_addr),
        .lk_pred(pred_o[1]), .lk_ctr(ctr_o[1]), .upd_valid(upd_valid),
        .upd_addr(upd_addr), .upd_taken(upd_taken));

    gbp_predictor #(.TBL_BITS(TB), .COL_BITS(0)) dut_hist_i (
        .clk(clk), .rst_n(rst_n), .hash_mode(hash_mode), .lk_addr(lk_addr),
        .lk_pred(pred_o[2]), .lk_ctr(ctr_o[2]), .upd_valid(upd_valid),
        .upd_addr(upd_addr), .upd_taken(upd_taken));

    function automatic int colbits(int k);
        if (k == 0) return 2;
        if (k == 1) return TB;
        return 0;
    endfunction

    function automatic int midx(int k, int addr, int hist, bit mode);
        int c;
        int r;
        int col;
        int ra;
        int h;
        int row;
        c   = colbits(k);
        r   = TB - c;
        col = addr & ((1 << c) - 1);
        ra  = (addr >> c) & ((1 << r) - 1);
        h   = hist & ((1 << r) - 1);
        row = mode ? (h ^ ra) : h;
        return (row << c) | col;
    endfunction

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // compare every instance against the model; called in the low clock half
    task automatic lookup_all(int addr, string req);
        lk_addr = addr[TB-1:0];
        #1;
        for (int k = 0; k < NINST; k++) begin
            int e;
            e = mctr[k][midx(k, addr, mhist[k], hash_mode)];
            check_eq(req, $sformatf("inst%0d addr%0d ctr", k, addr), int'(ctr_o[k]), e);
            check_eq(req, $sformatf("inst%0d addr%0d pred", k, addr), int'(pred_o[k]), e >> 1);
        end
    endtask

    task automatic model_update(int addr, bit taken);
        for (int k = 0; k < NINST; k++) begin
            int i;
            int r;
            i = midx(k, addr, mhist[k], hash_mode);
            if (taken && mctr[k][i] < 3) mctr[k][i]++;
            if (!taken && mctr[k][i] > 0) mctr[k][i]--;
            r = TB - colbits(k);
            mhist[k] = ((mhist[k] << 1) | int'(taken)) & ((1 << r) - 1);
        end
    endtask

    task automatic update(int addr, bit taken);
        @(negedge clk);
        upd_valid = 1'b1;
        upd_addr  = addr[TB-1:0];
        upd_taken = taken;
        @(posedge clk);
        model_update(addr, taken);
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        lk_addr = 6'd21;
        #1;
        check_eq("R1", "inst0 ctr after reset", int'(ctr_o[0]), 1);
        check_eq("R1", "inst2 pred after reset", int'(pred_o[2]), 0);
        lookup_all(0, "R1");
        lookup_all(63, "R1");
    endtask

    task automatic t_saturate;
        int up_exp [3] = '{2, 3, 3};
        int dn_exp [4] = '{2, 1, 0, 0};
        hash_mode = 1'b0;
        for (int i = 0; i < 3; i++) begin
            update(5, 1'b1);
            lookup_all(5, "R3");
            check_eq("R3", "addr-only counter up", int'(ctr_o[1]), up_exp[i]);
            check_eq("R2", "addr-only pred up", int'(pred_o[1]), 1);
        end
        for (int i = 0; i < 4; i++) begin
            update(5, 1'b0);
            lookup_all(5, "R3");
            check_eq("R3", "addr-only counter down", int'(ctr_o[1]), dn_exp[i]);
            check_eq("R2", "addr-only pred down", int'(pred_o[1]), dn_exp[i] >> 1);
        end
        lookup_all(6, "R5");
        check_eq("R5", "neighbour column untouched", int'(ctr_o[1]), 1);
    endtask

    task automatic t_history;
        hash_mode = 1'b0;
        for (int i = 0; i < 6; i++) update(12, 1'b0);
        update(40, 1'b1);
        update(40, 1'b0);
        update(40, 1'b1);
        check_eq("R4", "model history 101", mhist[2], 5);
        for (int a = 0; a < 64; a += 9) lookup_all(a, "R6");
        for (int i = 0; i < 4; i++) update(i * 3, 1'b1);
        for (int a = 1; a < 64; a += 7) lookup_all(a, "R4");
    endtask

    task automatic t_idle;
        @(negedge clk);
        upd_valid = 1'b0;
        for (int i = 0; i < 6; i++) begin
            upd_addr  = 6'(i * 11);
            upd_taken = i[0];
            @(negedge clk);
        end
        for (int a = 0; a < 64; a += 5) lookup_all(a, "R4");
    endtask

    task automatic t_same_cycle;
        int old0;
        int i0;
        hash_mode = 1'b0;
        @(negedge clk);
        i0   = midx(0, 9, mhist[0], hash_mode);
        old0 = mctr[0][i0];
        upd_valid = 1'b1;
        upd_addr  = 6'd9;
        upd_taken = 1'b1;
        lk_addr   = 6'd9;
        #1;
        check_eq("R8", "lookup during update sees old", int'(ctr_o[0]), old0);
        @(posedge clk);
        model_update(9, 1'b1);
        @(negedge clk);
        upd_valid = 1'b0;
        lookup_all(9, "R8");
        check_eq("R8", "trained counter after edge", mctr[0][i0], (old0 < 3) ? old0 + 1 : 3);
    endtask

    task automatic t_hashed;
        int lfsr;
        lfsr = 32'h1d;
        hash_mode = 1'b1;
        for (int i = 0; i < 60; i++) begin
            lfsr = ((lfsr << 1) | (((lfsr >> 5) ^ (lfsr >> 4)) & 1)) & 32'hffff;
            update(lfsr & 63, lfsr[3]);
            lookup_all((lfsr >> 6) & 63, "R7");
        end
        for (int a = 0; a < 64; a += 3) lookup_all(a, "R7");
    endtask

    task automatic t_concat_sweep;
        int lfsr;
        lfsr = 32'h5a;
        hash_mode = 1'b0;
        for (int i = 0; i < 60; i++) begin
            lfsr = ((lfsr << 1) | (((lfsr >> 7) ^ (lfsr >> 3)) & 1)) & 32'hffff;
            update(lfsr & 63, lfsr[2]);
            lookup_all((lfsr >> 5) & 63, "R9");
        end
        for (int a = 0; a < 64; a += 4) lookup_all(a, "R6");
    endtask

    initial begin
        for (int k = 0; k < NINST; k++) begin
            mhist[k] = 0;
            for (int i = 0; i < 64; i++) mctr[k][i] = 1;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_saturate();
        t_history();
        t_idle();
        t_same_cycle();
        t_hashed();
        t_concat_sweep();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule